// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines into a single interrupt line toward a host processor. It keeps three eight-bit registers, one bit per input. The pending register records requests that await acknowledgement. The in-service register records levels the host has taken but not yet retired. The mask register holds back selected inputs from being signalled. Each input is either edge- or level-sensitive. The priority order is either fixed or rotating. Levels are retired by an explicit end-of-interrupt (EOI) command or automatically during the acknowledge sequence.

A small synchronous register port programs the block and issues EOI commands. It has a write strobe, a 2-bit address, 8-bit write data and combinational read data. The host acknowledges with two single-cycle pulses on `ack`. The first pulse picks a level and marks it in service. The second pulse returns an 8-bit vector: a programmable 5-bit base followed by the 3-bit level number. When a request vanishes before it is acknowledged, the block answers with the level-7 vector and changes no state.

Register writes: address 0 is control, with bit0 = rotating priority, bit1 = automatic EOI, bit2 reserved and kept at 0, and bits 7:3 = vector base. Address 1 is the mask (1 = masked). Address 2 selects the trigger per input (1 = level). Address 3 is the command register: bits 7:6 = 01 is a non-specific EOI, bits 7:6 = 10 is a specific EOI for the level in bits 2:0, and any other value does nothing. Register reads: address 0 returns the pending register, address 1 the mask, address 2 the in-service register, and address 3 the control register.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, int_out and vec_valid are 0, and the pending, in-service, mask and control registers read 0. The default configuration is all-edge triggering, fixed priority and normal EOI.
- R2: An edge-mode input sets its pending bit on a 0-to-1 change. The bit stays set after the input falls, until that level is granted by the first acknowledge pulse.
- R3: A level-mode input (its bit at address 2 set to 1) makes its pending bit follow the input one cycle later, including falling back to 0.
- R4: A masked pending request still shows in the pending register, but it never drives int_out. Unmasking it lets int_out rise.
- R5: Under fixed priority, IR0 is the highest level and IR7 the lowest. int_out is 1 only when the best unmasked pending level outranks every level that is in service.
- R6: The first acknowledge pulse moves the winning level from the pending register to the in-service register. The second pulse drives vec_out = {base, level} with vec_valid high for exactly one cycle.
- R7: If no unmasked request outranks the in-service levels at the first acknowledge pulse, the vector carries level 7 and no in-service bit is set.
- R8: A non-specific EOI (command bits 7:6 = 01) clears only the highest-priority bit set in the in-service register.
- R9: A specific EOI (command bits 7:6 = 10) clears exactly the in-service bit whose level is given in bits 2:0.
- R10: With automatic EOI (control bit1 = 1), the granted in-service bit is cleared at the second acknowledge pulse, with no command needed.
- R11: With rotating priority (control bit0 = 1), clearing the in-service bit of level L makes L+1 (mod 8) the highest level and L the lowest.
- R12: Reads return the pending register at address 0, the mask at 1, the in-service register at 2, and the control register at 3, with reserved control bit2 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines, IR0 in bit 0 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational on cfg_addr) |
| ack | input | 1 | Acknowledge pulse from the host |
| int_out | output | 1 | Interrupt request to the host |
| vec_out | output | 8 | Vector returned by the second acknowledge pulse |
| vec_valid | output | 1 | vec_out valid, one cycle |

## Verification
A corrupted in-service or priority-pointer bit does not stay hidden. It changes int_out in the same cycle, because a pending level suddenly outranks or fails to outrank the in-service set. It also changes the level inside the next vector, which appears at the second acknowledge pulse. A lost or stuck pending bit shows on a read of address 0 one cycle after the input changes. A wrong spurious decision shows as an in-service bit on a read of address 2 right after the first acknowledge pulse.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int IRQ_N  = 8;
  localparam int LVL_W  = $clog2(IRQ_N);
  localparam int DATA_W = 8;
  localparam int BASE_W = DATA_W - LVL_W;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_TRIG = 2'd2;
  localparam logic [1:0] A_CMD  = 2'd3;

  typedef enum logic [1:0] {
    CMD_NOP     = 2'b00,
    CMD_EOI_ANY = 2'b01,
    CMD_EOI_LVL = 2'b10,
    CMD_RSVD    = 2'b11
  } cmd_e;

  typedef struct packed {
    logic             hit;
    logic [LVL_W-1:0] lvl;
  } pick_t;

  // distance from the current top-priority level; 0 is best
  function automatic logic [LVL_W-1:0] rank_of(input logic [LVL_W-1:0] lvl,
                                               input logic [LVL_W-1:0] top);
    return lvl - top;
  endfunction

  function automatic logic outranks(input logic [LVL_W-1:0] a,
                                    input logic [LVL_W-1:0] b,
                                    input logic [LVL_W-1:0] top);
    return rank_of(a, top) < rank_of(b, top);
  endfunction

  function automatic logic [IRQ_N-1:0] lvl_onehot(input logic [LVL_W-1:0] lvl);
    logic [IRQ_N-1:0] v;
    v = '0;
    v[lvl] = 1'b1;
    return v;
  endfunction

  // best set bit of v, scanning from top upward with wrap
  function automatic pick_t pick_best(input logic [IRQ_N-1:0] v,
                                      input logic [LVL_W-1:0] top);
    pick_t p;
    logic [LVL_W-1:0] l;
    p = '0;
    for (int k = IRQ_N - 1; k >= 0; k--) begin
      l = top + LVL_W'(k);
      if (v[l]) begin
        p.hit = 1'b1;
        p.lvl = l;
      end
    end
    return p;
  endfunction

  function automatic logic [DATA_W-1:0] make_vector(input logic [BASE_W-1:0] base,
                                                    input logic [LVL_W-1:0] lvl);
    return {base, lvl};
  endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_prio_pkg::*;
(
  input  logic [IRQ_N-1:0] vec,
  input  logic [LVL_W-1:0] top,
  output logic             hit,
  output logic [LVL_W-1:0] lvl
);
  pick_t p;
  always_comb begin
    p   = pick_best(vec, top);
    hit = p.hit;
    lvl = p.lvl;
  end
endmodule

// File: rtl/irq_req_capture.sv
module irq_req_capture
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_N-1:0] irq_in,
  input  logic [IRQ_N-1:0] trig_level,
  input  logic [IRQ_N-1:0] grant_clr,
  output logic [IRQ_N-1:0] irr
);
  logic [IRQ_N-1:0] prev_q;
  logic [IRQ_N-1:0] rise;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq_in;
  end

  assign rise = irq_in & ~prev_q;

  for (genvar i = 0; i < IRQ_N; i++) begin : g_bit
    logic nxt;
    always_comb begin
      if (trig_level[i]) nxt = irq_in[i];
      else               nxt = (irr[i] & ~grant_clr[i]) | rise[i];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) irr[i] <= 1'b0;
      else        irr[i] <= nxt;
    end
  end
endmodule

// File: rtl/irq_service.sv
module irq_service
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rotate_en,
  input  logic [IRQ_N-1:0] grant_set,
  input  logic             eoi_any,
  input  logic             eoi_lvl_en,
  input  logic [LVL_W-1:0] eoi_lvl,
  input  logic             auto_clr,
  input  logic [LVL_W-1:0] auto_clr_lvl,
  output logic [IRQ_N-1:0] isr,
  output logic [LVL_W-1:0] top,
  output logic             isr_hit,
  output logic [LVL_W-1:0] isr_lvl
);
  logic             cmd_fire, auto_fire, clr_fire;
  logic [LVL_W-1:0] cmd_lvl, clr_lvl;
  logic [IRQ_N-1:0] clr_mask;
  logic [IRQ_N-1:0] isr_d;
  logic [LVL_W-1:0] top_d;

  irq_pick u_isr_pick (.vec(isr), .top(top), .hit(isr_hit), .lvl(isr_lvl));

  always_comb begin
    cmd_fire = 1'b0;
    cmd_lvl  = '0;
    if (eoi_any && isr_hit) begin
      cmd_fire = 1'b1;
      cmd_lvl  = isr_lvl;
    end else if (eoi_lvl_en && isr[eoi_lvl]) begin
      cmd_fire = 1'b1;
      cmd_lvl  = eoi_lvl;
    end
    auto_fire = auto_clr && isr[auto_clr_lvl];
    clr_fire  = cmd_fire | auto_fire;
    clr_lvl   = cmd_fire ? cmd_lvl : auto_clr_lvl;
    clr_mask  = (cmd_fire  ? lvl_onehot(cmd_lvl)      : '0)
              | (auto_fire ? lvl_onehot(auto_clr_lvl) : '0);
    isr_d     = (isr & ~clr_mask) | grant_set;
    if (!rotate_en)    top_d = '0;
    else if (clr_fire) top_d = clr_lvl + 1'b1;
    else               top_d = top;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr <= '0;
      top <= '0;
    end else begin
      isr <= isr_d;
      top <= top_d;
    end
  end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack,
  input  logic              grant_hit,
  input  logic [LVL_W-1:0]  grant_lvl,
  input  logic [BASE_W-1:0] base,
  input  logic              auto_eoi,
  output logic              take,
  output logic              auto_clr,
  output logic [LVL_W-1:0]  held_lvl,
  output logic              spur_q,
  output logic [DATA_W-1:0] vec_out,
  output logic              vec_valid
);
  logic phase_q;
  logic deliver;

  assign take     = ack & ~phase_q;
  assign deliver  = ack & phase_q;
  assign auto_clr = deliver & auto_eoi & ~spur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= 1'b0;
      held_lvl  <= '0;
      spur_q    <= 1'b0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= 1'b0;
      if (take) begin
        phase_q  <= 1'b1;
        spur_q   <= ~grant_hit;
        held_lvl <= grant_hit ? grant_lvl : LVL_W'(IRQ_N - 1);
      end else if (deliver) begin
        phase_q   <= 1'b0;
        vec_out   <= make_vector(base, held_lvl);
        vec_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_N-1:0]  irq_in,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              ack,
  output logic              int_out,
  output logic [DATA_W-1:0] vec_out,
  output logic              vec_valid
);
  localparam logic [DATA_W-1:0] CTRL_KEEP = ~(DATA_W'(1) << 2);

  logic [DATA_W-1:0] ctrl_q;
  logic [IRQ_N-1:0]  mask_q, trig_q;
  logic              rotate_en, auto_eoi;
  logic [BASE_W-1:0] base;

  logic [IRQ_N-1:0]  irr, isr, req_act, grant_set;
  logic [LVL_W-1:0]  top, req_lvl, isr_lvl, held_lvl;
  logic              req_hit, isr_hit, grant_hit;
  logic              ack_take, auto_clr, spur_q;
  logic              cmd_we, cmd_eoi_any, cmd_eoi_lvl, cmd_eoi;
  cmd_e              cmd_code;

  assign rotate_en = ctrl_q[0];
  assign auto_eoi  = ctrl_q[1];
  assign base      = ctrl_q[DATA_W-1:LVL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      trig_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_CTRL:  ctrl_q <= cfg_wdata & CTRL_KEEP;
        A_MASK:  mask_q <= cfg_wdata[IRQ_N-1:0];
        A_TRIG:  trig_q <= cfg_wdata[IRQ_N-1:0];
        default: ;
      endcase
    end
  end

  assign cmd_we      = cfg_we && (cfg_addr == A_CMD);
  assign cmd_code    = cmd_e'(cfg_wdata[DATA_W-1:DATA_W-2]);
  assign cmd_eoi_any = cmd_we && (cmd_code == CMD_EOI_ANY);
  assign cmd_eoi_lvl = cmd_we && (cmd_code == CMD_EOI_LVL);
  assign cmd_eoi     = cmd_eoi_any | cmd_eoi_lvl;

  always_comb begin
    case (cfg_addr)
      A_CTRL:  cfg_rdata = DATA_W'(irr);
      A_MASK:  cfg_rdata = DATA_W'(mask_q);
      A_TRIG:  cfg_rdata = DATA_W'(isr);
      default: cfg_rdata = ctrl_q;
    endcase
  end

  assign req_act = irr & ~mask_q;

  irq_pick u_req_pick (.vec(req_act), .top(top), .hit(req_hit), .lvl(req_lvl));

  assign grant_hit = req_hit && (!isr_hit || outranks(req_lvl, isr_lvl, top));
  assign int_out   = grant_hit;
  assign grant_set = (ack_take && grant_hit) ? lvl_onehot(req_lvl) : '0;

  irq_req_capture u_cap (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig_level(trig_q),
    .grant_clr(grant_set), .irr(irr)
  );

  irq_service u_svc (
    .clk(clk), .rst_n(rst_n), .rotate_en(rotate_en), .grant_set(grant_set),
    .eoi_any(cmd_eoi_any), .eoi_lvl_en(cmd_eoi_lvl),
    .eoi_lvl(cfg_wdata[LVL_W-1:0]), .auto_clr(auto_clr),
    .auto_clr_lvl(held_lvl), .isr(isr), .top(top),
    .isr_hit(isr_hit), .isr_lvl(isr_lvl)
  );

  irq_ack_seq u_ack (
    .clk(clk), .rst_n(rst_n), .ack(ack), .grant_hit(grant_hit),
    .grant_lvl(req_lvl), .base(base), .auto_eoi(auto_eoi),
    .take(ack_take), .auto_clr(auto_clr), .held_lvl(held_lvl),
    .spur_q(spur_q), .vec_out(vec_out), .vec_valid(vec_valid)
  );
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              int_out,
  input logic [IRQ_N-1:0]  irr,
  input logic [IRQ_N-1:0]  mask_q,
  input logic [IRQ_N-1:0]  isr,
  input logic [LVL_W-1:0]  top,
  input logic              ack_take,
  input logic              grant_hit,
  input logic [LVL_W-1:0]  req_lvl,
  input logic              cmd_eoi,
  input logic              cmd_eoi_any,
  input logic              rotate_en,
  input logic              spur_q,
  input logic              vec_valid,
  input logic [DATA_W-1:0] vec_out
);
  AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr & ~mask_q) != '0); // R4

  AST_FIXED_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rotate_en |=> top == '0); // R5

  AST_GRANT_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && grant_hit && !cmd_eoi) |=> isr[$past(req_lvl)]); // R6

  AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid); // R6

  AST_SPUR_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !grant_hit && !cmd_eoi) |=> isr == $past(isr)); // R7

  AST_SPUR_LVL7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && spur_q) |-> vec_out[LVL_W-1:0] == LVL_W'(IRQ_N - 1)); // R7

  AST_EOI_ANY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_eoi_any && !ack_take && isr != '0) |=>
      $countones(isr) + 1 == $countones($past(isr))); // R8
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .int_out(int_out), .irr(irr), .mask_q(mask_q),
  .isr(isr), .top(top), .ack_take(ack_take), .grant_hit(grant_hit),
  .req_lvl(req_lvl), .cmd_eoi(cmd_eoi), .cmd_eoi_any(cmd_eoi_any),
  .rotate_en(rotate_en), .spur_q(spur_q), .vec_valid(vec_valid),
  .vec_out(vec_out)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       ack = 1'b0;
  logic       int_out;
  logic [7:0] vec_out;
  logic       vec_valid;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ack(ack), .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a vector is delivered
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R6 got vector %h expected none", vec_out);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (vec_out !== e) begin
          n_fail++;
          $display("FAIL %s got vector %h expected %h", t, vec_out, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [7:0] exp);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic pulse_ack;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  // driver: expects a vector, then runs both acknowledge pulses
  task automatic ack_seq(input string req, input logic [7:0] exp);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    pulse_ack();
    pulse_ack();
  endtask

  task automatic edge_pulse(input logic [7:0] bits);
    @(negedge clk); irq_in = irq_in | bits;
    @(negedge clk); irq_in = irq_in & ~bits;
  endtask

  task automatic run_all;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 int_out", {7'd0, int_out}, 8'h00);
    check("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
    rd_check("R1 pending", 2'd0, 8'h00);
    rd_check("R1 in-service", 2'd2, 8'h00);
    rd_check("R1 mask", 2'd1, 8'h00);
    rd_check("R1 control", 2'd3, 8'h00);

    // base 1, reserved bit2 written high must read back 0
    wr(2'd0, 8'h0C);
    rd_check("R12 control reserved bit", 2'd3, 8'h08);

    edge_pulse(8'h08);
    rd_check("R2 edge held after fall", 2'd0, 8'h08);
    check("R5 int_out single", {7'd0, int_out}, 8'h01);
    exp_q.push_back(8'h0B); tag_q.push_back("R6 vector IR3");
    pulse_ack();
    rd_check("R2 pending cleared by grant", 2'd0, 8'h00);
    rd_check("R6 in-service IR3", 2'd2, 8'h08);
    pulse_ack();

    edge_pulse(8'h20);
    check("R5 lower level blocked", {7'd0, int_out}, 8'h00);
    edge_pulse(8'h02);
    check("R5 higher level raises int", {7'd0, int_out}, 8'h01);
    ack_seq("R5 vector IR1", 8'h09);
    rd_check("R6 nested in-service", 2'd2, 8'h0A);
    wr(2'd3, 8'h40);
    rd_check("R8 non-specific EOI", 2'd2, 8'h08);
    check("R5 IR5 still blocked by IR3", {7'd0, int_out}, 8'h00);
    wr(2'd3, 8'h83);
    rd_check("R9 specific EOI IR3", 2'd2, 8'h00);
    check("R9 int after EOI", {7'd0, int_out}, 8'h01);
    ack_seq("R6 vector IR5", 8'h0D);
    wr(2'd3, 8'h80);
    rd_check("R9 specific EOI on clear bit", 2'd2, 8'h20);
    wr(2'd3, 8'h85);
    rd_check("R9 specific EOI IR5", 2'd2, 8'h00);

    wr(2'd1, 8'h01);
    edge_pulse(8'h01);
    rd_check("R4 masked still pending", 2'd0, 8'h01);
    check("R4 masked no int", {7'd0, int_out}, 8'h00);
    rd_check("R12 mask readback", 2'd1, 8'h01);
    wr(2'd1, 8'h00);
    check("R4 unmask raises int", {7'd0, int_out}, 8'h01);
    ack_seq("R5 vector IR0", 8'h08);
    wr(2'd3, 8'h40);

    wr(2'd2, 8'h04);
    @(negedge clk); irq_in[2] = 1'b1;
    @(negedge clk);
    rd_check("R3 level follows high", 2'd0, 8'h04);
    check("R3 level int", {7'd0, int_out}, 8'h01);
    irq_in[2] = 1'b0;
    @(negedge clk);
    rd_check("R3 level follows low", 2'd0, 8'h00);
    exp_q.push_back(8'h0F); tag_q.push_back("R7 spurious vector");
    pulse_ack();
    rd_check("R7 no in-service on spurious", 2'd2, 8'h00);
    pulse_ack();
    wr(2'd2, 8'h00);

    wr(2'd0, 8'h0A);
    edge_pulse(8'h10);
    exp_q.push_back(8'h0C); tag_q.push_back("R10 auto vector");
    pulse_ack();
    rd_check("R10 in-service during sequence", 2'd2, 8'h10);
    pulse_ack();
    rd_check("R10 auto cleared", 2'd2, 8'h00);

    wr(2'd0, 8'h09);
    edge_pulse(8'h04);
    ack_seq("R11 vector IR2", 8'h0A);
    wr(2'd3, 8'h40);
    edge_pulse(8'h42);
    ack_seq("R11 rotated pick IR6", 8'h0E);
    check("R11 IR1 below IR6", {7'd0, int_out}, 8'h00);
    wr(2'd3, 8'h40);
    ack_seq("R11 vector IR1", 8'h09);
    wr(2'd3, 8'h40);
    rd_check("R11 in-service empty", 2'd2, 8'h00);
    repeat (3) @(negedge clk);
    check("R6 scoreboard drained", 8'(exp_q.size()), 8'h00);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule